// File: doc/BRIEF.md
# Program Counter Stack and Branch Sequencer

This block produces the program fetch address for a small 4-bit processor core. It holds a bank of program counters with a rotating pointer. The counter that the pointer selects is the one in use, so the bank doubles as a shallow return stack and needs no memory-based stack. Each accepted instruction comes in as its opcode byte and, for two-byte forms, the operand byte. The block then advances the active counter, loads a jump target into it, or moves the pointer for a call or a return.

Conditional branches and counted loops stay inside a 256-word page. A 4-bit condition mask selects which status tests count toward the branch. Indirect jumps take their low address byte from a register pair that the core supplies. A return also asks the core to load the accumulator with a 4-bit constant from the opcode. Fetching from program memory and the index-register file are outside this block.

Top module: `pcs_branch_unit`

## Requirements
- R1: While `rst` is high on a rising edge, the pointer and all counters clear. Afterwards `fetch_addr` reads 0x000 and `acc_load_valid` reads 0.
- R2: On a cycle with `ins_valid` low, `fetch_addr` does not change, whatever the other inputs are.
- R3: One-byte instructions advance the address by 1. Two-byte immediate loads (opcode 0010rrr0) advance it by 2. The 12-bit address wraps from 0xFFF to 0x000. Opcodes 0011rrr0, 0000xxxx and the other non-branch opcodes count as one-byte instructions.
- R4: An unconditional jump (opcode 0100hhhh) sets the address to {hhhh, operand byte}.
- R5: A call (opcode 0101hhhh) stores the call address + 2 in the current counter, advances the pointer by one and sets the address to {hhhh, operand byte}.
- R6: A return (opcode 1100dddd) moves the pointer back by one, so the address becomes the stored return address. One cycle after it is accepted, `acc_load_valid` pulses high for exactly one cycle with `acc_load_data` = dddd.
- R7: A conditional jump (opcode 0001cccc) is taken when (c2 AND `acc_zero`) OR (c1 AND `carry`) OR (c0 AND NOT `test_n`), XOR c3. Mask 0000 therefore never jumps, and mask 1000 always jumps. When not taken, the address advances by 2.
- R8: A taken conditional jump keeps bits 11..8 of (instruction address + 2) and puts the operand byte in bits 7..0, so a jump from the last two words of a page lands in the next page.
- R9: An increment-and-skip (opcode 0111rrrr) with `isz_zero` low jumps in-page, using the same page rule as R8. With `isz_zero` high it advances by 2.
- R10: An indirect jump (opcode 0011rrr1) sets bits 7..0 to `pair_data` and keeps bits 11..8 of (instruction address + 1).
- R11: The pointer wraps modulo 4. Three nested calls return in order. A fourth call overwrites the oldest saved address, with no error indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | An instruction is accepted on this edge |
| ins_op | input | 8 | Opcode byte |
| ins_arg | input | 8 | Operand byte of two-byte instructions |
| acc_zero | input | 1 | Accumulator equals zero |
| carry | input | 1 | Carry flag |
| test_n | input | 1 | Active-low test pin |
| isz_zero | input | 1 | Incremented index register is zero |
| pair_data | input | 8 | Register pair, even register in bits 7..4 |
| fetch_addr | output | ADDR_W | Active program counter |
| acc_load_valid | output | 1 | Accumulator load request |
| acc_load_data | output | 4 | Value to load into the accumulator |

## Verification
An instruction is accepted on a rising edge, and the new `fetch_addr` is visible from that same edge. The bench therefore drives each instruction on the falling edge and samples 1 ns after the next rising edge. The accumulator request is registered on that same edge, so it is checked at the same sample point. One further instruction later, the bench checks that the request has dropped again. The address is checked after every instruction, so each page-crossing and stack-wrap case is compared at the exact cycle it takes effect.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [2:0] {
        OP_SEQ1, OP_SEQ2, OP_JUN, OP_JMS, OP_BBL, OP_JCN, OP_ISZ, OP_JIN
    } op_kind_e;

    localparam int PAGE_BITS = 8;
    localparam int IMM_W     = 4;

    // Classify an opcode byte by its effect on the program counter
    function automatic op_kind_e classify(input logic [7:0] op);
        op_kind_e k;
        unique case (op[7:4])
            4'h1:    k = OP_JCN;
            4'h2:    k = op[0] ? OP_SEQ1 : OP_SEQ2;
            4'h3:    k = op[0] ? OP_JIN : OP_SEQ1;
            4'h4:    k = OP_JUN;
            4'h5:    k = OP_JMS;
            4'h7:    k = OP_ISZ;
            4'hC:    k = OP_BBL;
            default: k = OP_SEQ1;
        endcase
        return k;
    endfunction

    // Masked status tests, ORed, then optionally inverted
    function automatic logic cond_hit(input logic [3:0] mask, input logic az,
                                      input logic cy, input logic tn);
        logic any;
        any = (mask[2] & az) | (mask[1] & cy) | (mask[0] & ~tn);
        return any ^ mask[3];
    endfunction

endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
    import pcs_pkg::*;
(
    input  logic [7:0] op,
    input  logic       acc_zero,
    input  logic       carry,
    input  logic       test_n,
    output op_kind_e   kind,
    output logic       cond_ok
);
    always_comb begin
        kind    = classify(op);
        cond_ok = cond_hit(op[3:0], acc_zero, carry, test_n);
    end
endmodule

// File: rtl/pcs_target.sv
module pcs_target
    import pcs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  op_kind_e           kind,
    input  logic [3:0]         nib,
    input  logic [7:0]         arg,
    input  logic [ADDR_W-1:0]  cur_pc,
    input  logic               cond_ok,
    input  logic               isz_zero,
    input  logic [7:0]         pair,
    output logic [ADDR_W-1:0]  cur_next,
    output logic [ADDR_W-1:0]  push_val,
    output logic               push,
    output logic               pop
);
    localparam int HI_W = ADDR_W - PAGE_BITS;

    logic [ADDR_W-1:0] inc1, inc2, far, near2, near1;

    always_comb begin
        inc1  = cur_pc + ADDR_W'(1);
        inc2  = cur_pc + ADDR_W'(2);
        far   = ADDR_W'({nib, arg});
        near2 = {inc2[ADDR_W-1 -: HI_W], arg};
        near1 = {inc1[ADDR_W-1 -: HI_W], pair};
        push      = (kind == OP_JMS);
        pop       = (kind == OP_BBL);
        push_val  = far;
        unique case (kind)
            OP_SEQ2: cur_next = inc2;
            OP_JUN:  cur_next = far;
            OP_JMS:  cur_next = inc2;
            OP_JCN:  cur_next = cond_ok ? near2 : inc2;
            OP_ISZ:  cur_next = isz_zero ? inc2 : near2;
            OP_JIN:  cur_next = near1;
            default: cur_next = inc1;
        endcase
    end
endmodule

// File: rtl/pcs_bank.sv
module pcs_bank #(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic [ADDR_W-1:0] cur_next,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] push_val,
    output logic [ADDR_W-1:0] cur_pc
);
    localparam int PW = $clog2(DEPTH);

    logic [PW-1:0]     ptr;
    logic [PW-1:0]     ptr_up, ptr_dn;
    logic [ADDR_W-1:0] slot [DEPTH];

    assign ptr_up = ptr + 1'b1;
    assign ptr_dn = ptr - 1'b1;

    always_ff @(posedge clk) begin
        if (rst)              ptr <= '0;
        else if (adv && push) ptr <= ptr_up;
        else if (adv && pop)  ptr <= ptr_dn;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam logic [PW-1:0] IDX = PW'(g);
        logic [ADDR_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                          q <= '0;
            else if (adv && push && IDX == ptr_up) q <= push_val;
            else if (adv && IDX == ptr)       q <= cur_next;
        end
        assign slot[g] = q;
    end

    assign cur_pc = slot[ptr];
endmodule

// File: rtl/pcs_branch_unit.sv
module pcs_branch_unit
    import pcs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [7:0]        ins_op,
    input  logic [7:0]        ins_arg,
    input  logic              acc_zero,
    input  logic              carry,
    input  logic              test_n,
    input  logic              isz_zero,
    input  logic [7:0]        pair_data,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              acc_load_valid,
    output logic [3:0]        acc_load_data
);
    op_kind_e          kind;
    logic              cond_ok, push, pop;
    logic [ADDR_W-1:0] cur_next, push_val;

    pcs_decode u_dec (
        .op(ins_op), .acc_zero(acc_zero), .carry(carry), .test_n(test_n),
        .kind(kind), .cond_ok(cond_ok)
    );

    pcs_target #(.ADDR_W(ADDR_W)) u_tgt (
        .kind(kind), .nib(ins_op[3:0]), .arg(ins_arg), .cur_pc(fetch_addr),
        .cond_ok(cond_ok), .isz_zero(isz_zero), .pair(pair_data),
        .cur_next(cur_next), .push_val(push_val), .push(push), .pop(pop)
    );

    pcs_bank #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_bank (
        .clk(clk), .rst(rst), .adv(ins_valid), .cur_next(cur_next),
        .push(push), .pop(pop), .push_val(push_val), .cur_pc(fetch_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_load_valid <= 1'b0;
            acc_load_data  <= '0;
        end else begin
            acc_load_valid <= ins_valid && pop;
            if (ins_valid && pop) acc_load_data <= ins_op[IMM_W-1:0];
        end
    end
endmodule

// File: rtl/pcs_branch_chk.sv
module pcs_branch_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              ins_valid,
    input logic [7:0]        ins_op,
    input logic [7:0]        ins_arg,
    input logic              isz_zero,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              acc_load_valid,
    input logic [3:0]        acc_load_data
);
    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ins_valid |=> $stable(fetch_addr));

    // R4
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_op[7:4] == 4'h4) |=>
        fetch_addr == ADDR_W'({$past(ins_op[3:0]), $past(ins_arg)}));

    // R6
    return_load_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_op[7:4] == 4'hC) |=>
        (acc_load_valid && acc_load_data == $past(ins_op[3:0])));

    // R6
    load_only_after_return_chk: assert property (@(posedge clk) disable iff (rst)
        acc_load_valid |-> $past(ins_valid && ins_op[7:4] == 4'hC));

    // R7
    cond_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_op[7:4] == 4'h1) |=>
        (fetch_addr[7:0] == $past(ins_arg) ||
         fetch_addr == $past(fetch_addr) + ADDR_W'(2)));

    // R9
    skip_fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_op[7:4] == 4'h7 && isz_zero) |=>
        fetch_addr == $past(fetch_addr) + ADDR_W'(2));
endmodule

bind pcs_branch_unit pcs_branch_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_op(ins_op),
    .ins_arg(ins_arg), .isz_zero(isz_zero), .fetch_addr(fetch_addr),
    .acc_load_valid(acc_load_valid), .acc_load_data(acc_load_data)
);

// File: tb/tb_pcs_branch_unit.sv
`timescale 1ns/1ps
module tb_pcs_branch_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 1'b0;
    logic [7:0]  ins_op = 8'h00, ins_arg = 8'h00, pair_data = 8'h00;
    logic        acc_zero = 1'b0, carry = 1'b0, test_n = 1'b1, isz_zero = 1'b0;
    logic [11:0] fetch_addr;
    logic        acc_load_valid;
    logic [3:0]  acc_load_data;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    pcs_branch_unit dut (
        .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_op(ins_op),
        .ins_arg(ins_arg), .acc_zero(acc_zero), .carry(carry), .test_n(test_n),
        .isz_zero(isz_zero), .pair_data(pair_data), .fetch_addr(fetch_addr),
        .acc_load_valid(acc_load_valid), .acc_load_data(acc_load_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] op, input logic [7:0] arg);
        @(negedge clk);
        ins_op = op; ins_arg = arg; ins_valid = 1'b1;
        @(posedge clk); #1;
        ins_valid = 1'b0;
    endtask

    task automatic go_to(input logic [11:0] a);
        step({4'h4, a[11:8]}, a[7:0]);
    endtask

    task automatic t_reset;
        chk("R1 addr", fetch_addr, 12'h000);
        chk("R1 load", acc_load_valid, 0);
    endtask

    task automatic t_idle;
        @(negedge clk); ins_op = 8'h4A; ins_arg = 8'h55;
        repeat (3) @(posedge clk);
        #1 chk("R2 idle", fetch_addr, 12'h000);
    endtask

    task automatic t_seq;
        step(8'h00, 8'h00); chk("R3 one-byte", fetch_addr, 12'h001);
        step(8'h24, 8'h99); chk("R3 two-byte", fetch_addr, 12'h003);
        step(8'h30, 8'h00); chk("R3 fetch-indirect", fetch_addr, 12'h004);
        go_to(12'hFFF);     chk("R4 jump", fetch_addr, 12'hFFF);
        step(8'hF2, 8'h00); chk("R3 wrap", fetch_addr, 12'h000);
        go_to(12'h123);     chk("R4 jump2", fetch_addr, 12'h123);
    endtask

    task automatic t_cond;
        go_to(12'h200);
        acc_zero = 1; step(8'h14, 8'hAB); chk("R7 az taken", fetch_addr, 12'h2AB);
        acc_zero = 0; step(8'h14, 8'hCD); chk("R7 az not", fetch_addr, 12'h2AD);
        step(8'h1C, 8'h10); chk("R7 inverted az", fetch_addr, 12'h210);
        carry = 1; step(8'h12, 8'h33); chk("R7 carry", fetch_addr, 12'h233);
        carry = 0; test_n = 0; step(8'h11, 8'h44); chk("R7 test low", fetch_addr, 12'h244);
        test_n = 1; step(8'h11, 8'h55); chk("R7 test high", fetch_addr, 12'h246);
        step(8'h10, 8'h66); chk("R7 mask never", fetch_addr, 12'h248);
        step(8'h18, 8'h77); chk("R7 mask always", fetch_addr, 12'h277);
        acc_zero = 1; step(8'h16, 8'h88); chk("R7 or of tests", fetch_addr, 12'h288);
        acc_zero = 0; step(8'h1E, 8'h99); chk("R7 inverted none", fetch_addr, 12'h299);
        go_to(12'h2FE);
        step(8'h18, 8'h10); chk("R8 page cross", fetch_addr, 12'h310);
    endtask

    task automatic t_skip;
        go_to(12'h500);
        isz_zero = 0; step(8'h73, 8'h40); chk("R9 nonzero jumps", fetch_addr, 12'h540);
        isz_zero = 1; step(8'h73, 8'h60); chk("R9 zero falls", fetch_addr, 12'h542);
        go_to(12'h5FF);
        isz_zero = 0; step(8'h7F, 8'h20); chk("R9 page", fetch_addr, 12'h620);
    endtask

    task automatic t_indirect;
        go_to(12'h7A0);
        pair_data = 8'h5C; step(8'h31, 8'h00); chk("R10 indirect", fetch_addr, 12'h75C);
        go_to(12'h7FF);
        pair_data = 8'h12; step(8'h3B, 8'h00); chk("R10 page", fetch_addr, 12'h812);
    endtask

    task automatic t_call;
        go_to(12'h100);
        step(8'h54, 8'h00); chk("R5 call", fetch_addr, 12'h400);
        chk("R6 no load on call", acc_load_valid, 0);
        step(8'h58, 8'h20); chk("R5 nested call", fetch_addr, 12'h820);
        step(8'hC7, 8'h00); chk("R6 return addr", fetch_addr, 12'h402);
        chk("R6 load valid", acc_load_valid, 1);
        chk("R6 load data", acc_load_data, 4'h7);
        step(8'h00, 8'h00); chk("R6 pulse ends", acc_load_valid, 0);
        chk("R3 after return", fetch_addr, 12'h403);
        step(8'hCA, 8'h00); chk("R6 outer return", fetch_addr, 12'h102);
        chk("R6 data2", acc_load_data, 4'hA);
    endtask

    task automatic t_wrap;
        step(8'h55, 8'h10); chk("R11 call1", fetch_addr, 12'h510);
        step(8'h56, 8'h20); chk("R11 call2", fetch_addr, 12'h620);
        step(8'h57, 8'h30); chk("R11 call3", fetch_addr, 12'h730);
        step(8'h58, 8'h40); chk("R11 call4", fetch_addr, 12'h840);
        step(8'hC0, 8'h00); chk("R11 ret4", fetch_addr, 12'h732);
        step(8'hC0, 8'h00); chk("R11 ret3", fetch_addr, 12'h622);
        step(8'hC0, 8'h00); chk("R11 ret2", fetch_addr, 12'h512);
        step(8'hC0, 8'h00); chk("R11 overwritten", fetch_addr, 12'h841);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk) rst = 1'b0;
        t_idle();
        t_seq();
        t_cond();
        t_skip();
        t_indirect();
        t_call();
        t_wrap();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule